// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side end of a four-wire serial programming link. The host drives a serial clock and a data-in line. It holds a select line low for the whole session. The block returns bytes on a data-out line. Each instruction is a fixed frame of four bytes, most significant bit first. The block samples input on rising serial-clock edges and updates output on falling edges. Both the serial clock and the select line are synchronized into the block's own clock, so each serial-clock phase must last at least two block clocks.

A decoded instruction turns into one request on a valid/ready port towards the memory sub-blocks. These are program memory (word addressed, with a high/low byte select), data memory (byte addressed), the lock-bit store and the signature store. Read data returns on a one-beat response channel and is shifted out during the fourth byte. The lock and fuse state comes in on plain status pins. Back-pressure rules are as follows. A request holds all of its fields until `req_ready` is seen high. An instruction that decodes while an earlier request is still waiting produces no request. Read data must be presented on `rsp_valid` before the serial clock falls after the third byte.

The host must first send an enable instruction. The block answers it by returning the enable key while the third byte arrives. Until that exchange, every other instruction is consumed and discarded.

Top module: `spt_target`

## Requirements
- R1: Input bits are taken on rising serial-clock edges, most significant bit first; `miso` changes only after a falling serial-clock edge (or while deselected).
- R2: Every instruction is four bytes; the bit counter moves only on rising edges. For the enable instruction (0xAC, 0x53, any, any) the byte 0x53 is returned during byte 3, and the next instruction is accepted only after all four bytes have been consumed, whatever was echoed.
- R3: Before an enable instruction has completed, no request is issued and nothing but the enable echo appears on `miso`.
- R4: While `prog_sel_n` is high, the bit counter is zero, the enabled state is cleared and `miso` is 0. On reselection, framing restarts at bit 0 and the enable must be repeated.
- R5: Program read (first byte 0010_H000) issues op 0 after byte 3. The word address is {byte2[1:0], byte3}, `req_hi` is H, and the response byte is shifted out during byte 4.
- R6: Program write (first byte 0100_H000) issues op 1 after byte 4, with the same address and H, and `req_wdata` = byte 4.
- R7: Data read (0xA0) issues op 2 after byte 3 and returns the response during byte 4. Data write (0xC0) issues op 3 after byte 4 with `req_wdata` = byte 4. Both use address byte3[6:0]; byte3 bit 7 and byte 2 are ignored.
- R8: Chip erase (0xAC followed by a byte 100x_xxxx) issues op 4 after byte 4.
- R9: Lock/fuse read (0x58) issues no request. Byte 4 returns lock bit 1, lock bit 2 and the serial-enable fuse in bits 7, 6 and 5, taken from `lock_state_n[0]`, `lock_state_n[1]` and `serial_en_fuse_n` (0 = programmed). All other bits are 0.
- R10: Lock write (0xAC followed by 1111_1xx1) issues op 5 after byte 4, with `req_wdata` = byte 2.
- R11: Signature read (0x30) issues op 6 after byte 3 with address byte3[1:0] and returns the response during byte 4. When both lock bits are programmed (`lock_state_n` = 00), it issues no request and returns 0x00.
- R12: An unrecognized first byte completes its four bytes with no request and `miso` held at 0.
- R13: A request held against a low `req_ready` keeps `req_valid`, `req_op`, `req_addr`, `req_hi` and `req_wdata` stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| prog_sel_n | input | 1 | Programming select, active low (asynchronous) |
| sck | input | 1 | Serial clock from the host (asynchronous) |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| lock_state_n | input | 2 | Lock bits, [0] = bit 1, [1] = bit 2, 0 = programmed |
| serial_en_fuse_n | input | 1 | Serial-enable fuse state, 0 = programmed |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_op | output | 3 | Operation: 0 prog read, 1 prog write, 2 data read, 3 data write, 4 erase, 5 lock write, 6 signature read |
| req_addr | output | PROG_AW | Word, byte or signature address |
| req_hi | output | 1 | High byte select for program operations |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Read data valid (one beat) |
| rsp_data | input | 8 | Read data |

## Verification
The hardest state to reach from the ports is a host that has lost byte framing, since a correct host never produces it. The stimulus sends one extra serial-clock pulse before an enable instruction. The echo must then fail, and the following requests must stay silent. The stimulus then adds 31 more single pulses, so the frame boundary lines up again, and a repeated enable must echo correctly. A second hard case is a request that waits on a low `req_ready`. The memory model withholds ready for many cycles while the bench watches the held request at the port.

// File: rtl/spt_pkg.sv
package spt_pkg;

  localparam int BYTE_BITS   = 8;
  localparam int FRAME_BYTES = 4;
  localparam int FRAME_BITS  = BYTE_BITS * FRAME_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BITS);

  localparam logic [7:0] CTRL_PREFIX = 8'hAC;
  localparam logic [7:0] ENABLE_KEY  = 8'h53;
  localparam logic [7:0] PROG_RD_PAT = 8'h20;
  localparam logic [7:0] PROG_WR_PAT = 8'h40;
  localparam logic [7:0] HI_SEL_MASK = 8'hF7;
  localparam logic [7:0] DATA_RD_OPC = 8'hA0;
  localparam logic [7:0] DATA_WR_OPC = 8'hC0;
  localparam logic [7:0] LOCK_RD_OPC = 8'h58;
  localparam logic [7:0] SIG_RD_OPC  = 8'h30;

  typedef enum logic [2:0] {
    OP_PROG_RD = 3'd0,
    OP_PROG_WR = 3'd1,
    OP_DATA_RD = 3'd2,
    OP_DATA_WR = 3'd3,
    OP_ERASE   = 3'd4,
    OP_LOCK_WR = 3'd5,
    OP_SIG_RD  = 3'd6
  } mem_op_e;

  typedef enum logic [3:0] {
    K_NONE,
    K_ENABLE,
    K_ERASE,
    K_LOCK_WR,
    K_PROG_RD,
    K_PROG_WR,
    K_DATA_RD,
    K_DATA_WR,
    K_LOCK_RD,
    K_SIG_RD
  } cmd_e;

  function automatic cmd_e classify(input logic [7:0] first, input logic [7:0] second);
    cmd_e k;
    k = K_NONE;
    if (first == CTRL_PREFIX) begin
      if (second == ENABLE_KEY)                         k = K_ENABLE;
      else if (second[7:5] == 3'b100)                   k = K_ERASE;
      else if (second[7:3] == 5'b11111 && second[0])    k = K_LOCK_WR;
    end else if ((first & HI_SEL_MASK) == PROG_RD_PAT)  k = K_PROG_RD;
    else if ((first & HI_SEL_MASK) == PROG_WR_PAT)      k = K_PROG_WR;
    else if (first == DATA_RD_OPC)                      k = K_DATA_RD;
    else if (first == DATA_WR_OPC)                      k = K_DATA_WR;
    else if (first == LOCK_RD_OPC)                      k = K_LOCK_RD;
    else if (first == SIG_RD_OPC)                       k = K_SIG_RD;
    return k;
  endfunction

endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic prog_sel_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic idle
);

  localparam int LANES = 3;

  logic [SYNC_STAGES-1:0][LANES-1:0] stage;
  logic [LANES-1:0] last;
  logic sck_s;
  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= {SYNC_STAGES{3'b100}};
      sck_prev <= 1'b0;
    end else begin
      stage    <= {stage[SYNC_STAGES-2:0], {prog_sel_n, mosi, sck}};
      sck_prev <= sck_s;
    end
  end

  assign last     = stage[SYNC_STAGES-1];
  assign sck_s    = last[0];
  assign mosi_s   = last[1];
  assign idle     = last[2];
  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;

endmodule

// File: rtl/spt_shift.sv
module spt_shift
  import spt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             mosi_s,
  input  logic             tx_load,
  input  logic [7:0]       tx_byte,
  output logic             byte_vld,
  output logic [1:0]       byte_idx,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             miso
);

  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  assign byte_vld = sck_rise && !idle && (bit_cnt[2:0] == 3'd7);
  assign byte_idx = bit_cnt[CNT_W-1:3];
  assign byte_val = {rx_sh[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      tx_sh   <= '0;
      bit_cnt <= '0;
      miso    <= 1'b0;
    end else if (idle) begin
      rx_sh   <= '0;
      tx_sh   <= '0;
      bit_cnt <= '0;
      miso    <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= byte_val;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (tx_load) begin
        if (sck_fall) begin
          miso  <= tx_byte[7];
          tx_sh <= {tx_byte[6:0], 1'b0};
        end else begin
          tx_sh <= tx_byte;
        end
      end else if (sck_fall) begin
        miso  <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spt_decode.sv
module spt_decode
  import spt_pkg::*;
#(
  parameter int PROG_AW = 10,
  parameter int DATA_AW = 7,
  parameter int SIG_AW  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               byte_vld,
  input  logic [1:0]         byte_idx,
  input  logic [7:0]         byte_val,
  input  logic [1:0]         lock_state_n,
  input  logic               serial_en_fuse_n,
  input  logic               req_ready,
  input  logic               rsp_valid,
  input  logic [7:0]         rsp_data,
  output logic               tx_load,
  output logic [7:0]         tx_byte,
  output logic               req_valid,
  output logic [2:0]         req_op,
  output logic [PROG_AW-1:0] req_addr,
  output logic               req_hi,
  output logic [7:0]         req_wdata,
  output logic               enabled
);

  logic [7:0] hdr0, hdr1, hdr2;
  cmd_e       cmd;
  logic [15:0] rd_word, wr_word;
  logic       issue, issue_rd, set_en, busy, accept, rd_wait;
  mem_op_e    nx_op;
  logic [PROG_AW-1:0] nx_addr;
  logic       nx_hi;
  logic [7:0] nx_wd;

  assign cmd     = classify(hdr0, hdr1);
  assign rd_word = {hdr1, byte_val};
  assign wr_word = {hdr1, hdr2};
  assign busy    = req_valid && !req_ready;
  assign accept  = issue && !busy;

  always_comb begin
    tx_load  = 1'b0;
    tx_byte  = '0;
    issue    = 1'b0;
    issue_rd = 1'b0;
    set_en   = 1'b0;
    nx_op    = OP_PROG_RD;
    nx_addr  = '0;
    nx_hi    = 1'b0;
    nx_wd    = '0;
    if (byte_vld) begin
      case (byte_idx)
        2'd1: begin
          if (hdr0 == CTRL_PREFIX && byte_val == ENABLE_KEY) begin
            tx_load = 1'b1;
            tx_byte = ENABLE_KEY;
          end
        end
        2'd2: begin
          if (enabled) begin
            case (cmd)
              K_PROG_RD: begin
                issue    = 1'b1;
                issue_rd = 1'b1;
                nx_op    = OP_PROG_RD;
                nx_addr  = rd_word[PROG_AW-1:0];
                nx_hi    = hdr0[3];
              end
              K_DATA_RD: begin
                issue    = 1'b1;
                issue_rd = 1'b1;
                nx_op    = OP_DATA_RD;
                nx_addr[DATA_AW-1:0] = byte_val[DATA_AW-1:0];
              end
              K_LOCK_RD: begin
                tx_load = 1'b1;
                tx_byte = {lock_state_n[0], lock_state_n[1], serial_en_fuse_n, 5'b0};
              end
              K_SIG_RD: begin
                if (lock_state_n == 2'b00) begin
                  tx_load = 1'b1;
                  tx_byte = 8'h00;
                end else begin
                  issue    = 1'b1;
                  issue_rd = 1'b1;
                  nx_op    = OP_SIG_RD;
                  nx_addr[SIG_AW-1:0] = byte_val[SIG_AW-1:0];
                end
              end
              default: ;
            endcase
          end
        end
        2'd3: begin
          if (cmd == K_ENABLE) set_en = 1'b1;
          if (enabled) begin
            case (cmd)
              K_ERASE: begin
                issue = 1'b1;
                nx_op = OP_ERASE;
              end
              K_PROG_WR: begin
                issue   = 1'b1;
                nx_op   = OP_PROG_WR;
                nx_addr = wr_word[PROG_AW-1:0];
                nx_hi   = hdr0[3];
                nx_wd   = byte_val;
              end
              K_DATA_WR: begin
                issue = 1'b1;
                nx_op = OP_DATA_WR;
                nx_addr[DATA_AW-1:0] = hdr2[DATA_AW-1:0];
                nx_wd = byte_val;
              end
              K_LOCK_WR: begin
                issue = 1'b1;
                nx_op = OP_LOCK_WR;
                nx_wd = hdr1;
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end else if (rsp_valid && rd_wait) begin
      tx_load = 1'b1;
      tx_byte = rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr0    <= '0;
      hdr1    <= '0;
      hdr2    <= '0;
      enabled <= 1'b0;
      rd_wait <= 1'b0;
    end else if (idle) begin
      hdr0    <= '0;
      hdr1    <= '0;
      hdr2    <= '0;
      enabled <= 1'b0;
      rd_wait <= 1'b0;
    end else begin
      if (byte_vld) begin
        case (byte_idx)
          2'd0:    hdr0 <= byte_val;
          2'd1:    hdr1 <= byte_val;
          2'd2:    hdr2 <= byte_val;
          default: ;
        endcase
      end
      if (set_en) enabled <= 1'b1;
      if (accept && issue_rd) rd_wait <= 1'b1;
      else if (rsp_valid)     rd_wait <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_op    <= '0;
      req_addr  <= '0;
      req_hi    <= 1'b0;
      req_wdata <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (accept) begin
        req_valid <= 1'b1;
        req_op    <= nx_op;
        req_addr  <= nx_addr;
        req_hi    <= nx_hi;
        req_wdata <= nx_wd;
      end
    end
  end

endmodule

// File: rtl/spt_target.sv
module spt_target
  import spt_pkg::*;
#(
  parameter int PROG_AW     = 10,
  parameter int DATA_AW     = 7,
  parameter int SIG_AW      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_sel_n,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  input  logic [1:0]         lock_state_n,
  input  logic               serial_en_fuse_n,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [2:0]         req_op,
  output logic [PROG_AW-1:0] req_addr,
  output logic               req_hi,
  output logic [7:0]         req_wdata,
  input  logic               rsp_valid,
  input  logic [7:0]         rsp_data
);

  logic             sck_rise, sck_fall, mosi_s, idle;
  logic             byte_vld;
  logic [1:0]       byte_idx;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] bit_cnt;
  logic             tx_load;
  logic [7:0]       tx_byte;
  logic             enabled;

  spt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .mosi       (mosi),
    .prog_sel_n (prog_sel_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .mosi_s     (mosi_s),
    .idle       (idle)
  );

  spt_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .byte_vld (byte_vld),
    .byte_idx (byte_idx),
    .byte_val (byte_val),
    .bit_cnt  (bit_cnt),
    .miso     (miso)
  );

  spt_decode #(
    .PROG_AW (PROG_AW),
    .DATA_AW (DATA_AW),
    .SIG_AW  (SIG_AW)
  ) u_dec (
    .clk              (clk),
    .rst_n            (rst_n),
    .idle             (idle),
    .byte_vld         (byte_vld),
    .byte_idx         (byte_idx),
    .byte_val         (byte_val),
    .lock_state_n     (lock_state_n),
    .serial_en_fuse_n (serial_en_fuse_n),
    .req_ready        (req_ready),
    .rsp_valid        (rsp_valid),
    .rsp_data         (rsp_data),
    .tx_load          (tx_load),
    .tx_byte          (tx_byte),
    .req_valid        (req_valid),
    .req_op           (req_op),
    .req_addr         (req_addr),
    .req_hi           (req_hi),
    .req_wdata        (req_wdata),
    .enabled          (enabled)
  );

endmodule

// File: rtl/spt_target_chk.sv
module spt_target_chk #(
  parameter int PROG_AW = 10,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miso,
  input logic               sck_rise,
  input logic               sck_fall,
  input logic               idle,
  input logic               enabled,
  input logic [CW-1:0]      bit_cnt,
  input logic [1:0]         lock_state_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [2:0]         req_op,
  input logic [PROG_AW-1:0] req_addr,
  input logic               req_hi,
  input logic [7:0]         req_wdata
);

  // R1: output moves only after a falling serial-clock edge or while deselected
  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall || idle));

  // R2: framing counter advances only on rising serial-clock edges
  a_r2_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_cnt) |-> $past(sck_rise || idle));

  // R3: no request before enable
  a_r3_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(enabled));

  // R4: deselected port is quiet and unframed
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> (!miso && !enabled && bit_cnt == '0));

  // R11: no signature request with both lock bits programmed
  a_r11_sig_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_op == 3'd6) |-> $past(lock_state_n) != 2'b00);

  // R13: held request stays stable
  a_r13_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_addr)
                                   && $stable(req_hi) && $stable(req_wdata)));

endmodule

bind spt_target spt_target_chk #(.PROG_AW(PROG_AW), .CW(spt_pkg::CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miso         (miso),
  .sck_rise     (sck_rise),
  .sck_fall     (sck_fall),
  .idle         (idle),
  .enabled      (enabled),
  .bit_cnt      (bit_cnt),
  .lock_state_n (lock_state_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .req_addr     (req_addr),
  .req_hi       (req_hi),
  .req_wdata    (req_wdata)
);

// File: tb/spt_target_test.sv
module spt_target_test;

  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_sel_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic [1:0] lock_state_n = 2'b11;
  logic serial_en_fuse_n = 1'b0;
  logic req_valid;
  logic req_ready = 1'b1;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr;
  logic req_hi;
  logic [7:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic          hi;
    logic [7:0]    wd;
  } req_t;

  req_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  spt_target uut (
    .clk(clk), .rst_n(rst_n), .prog_sel_n(prog_sel_n), .sck(sck), .mosi(mosi),
    .miso(miso), .lock_state_n(lock_state_n), .serial_en_fuse_n(serial_en_fuse_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_hi(req_hi), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] model(input logic [2:0] op, input logic [AW-1:0] a, input logic h);
    case (op)
      3'd0:    return a[7:0] ^ (h ? 8'hF0 : 8'h0F);
      3'd2:    return a[7:0] ^ 8'h3C;
      3'd6:    return 8'h1E + a[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // memory model: one-cycle read response
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready && (req_op == 3'd0 || req_op == 3'd2 || req_op == 3'd6)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= model(req_op, req_addr, req_hi);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      req_t got;
      got = '{op: req_op, addr: req_addr, hi: req_hi, wd: req_wdata};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R12 unexpected request: got op=%0d addr=%h hi=%0d wd=%h, expected none",
                 got.op, got.addr, got.hi, got.wd);
      end else begin
        req_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s request: got op=%0d addr=%h hi=%0d wd=%h, expected op=%0d addr=%h hi=%0d wd=%h",
                   t, got.op, got.addr, got.hi, got.wd, e.op, e.addr, e.hi, e.wd);
        end
      end
    end
  end

  task automatic expect_req(input logic [2:0] op, input logic [AW-1:0] a, input logic h,
                            input logic [7:0] wd, input string t);
    exp_q.push_back('{op: op, addr: a, hi: h, wd: wd});
    tag_q.push_back(t);
  endtask

  task automatic check8(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic sck_bit(input logic b, output logic r);
    @(negedge clk);
    mosi = b;
    repeat (8) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (8) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int k = 7; k >= 0; k--) begin
      logic r;
      sck_bit(o[k], r);
      i[k] = r;
    end
  endtask

  task automatic instr(input logic [31:0] cmd, output logic [31:0] back);
    for (int n = 3; n >= 0; n--) begin
      logic [7:0] rb;
      xfer(cmd[8*n +: 8], rb);
      back[8*n +: 8] = rb;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    logic d;
    pause(5);
    rst_n = 1'b1;
    pause(5);
    // R4: reset / deselected state
    check8("R4 reset miso", {7'b0, miso}, 8'h00);
    check8("R4 reset req_valid", {7'b0, req_valid}, 8'h00);

    prog_sel_n = 1'b0;
    pause(10);
    // R3: commands before enable are ignored
    instr(32'hC0_00_05_77, rb);
    instr(32'hA0_00_05_00, rb);
    check8("R3 read before enable byte4", rb[7:0], 8'h00);

    // R2: lost framing - stray pulse, failed echo, realign with 31 pulses
    sck_bit(1'b0, d);
    instr(32'hAC_53_00_00, rb);
    check8("R2 misaligned echo absent", rb[15:8], 8'h00);
    for (int p = 0; p < 31; p++) sck_bit(1'b0, d);
    instr(32'hAC_53_00_00, rb);
    check8("R2 enable echo byte3", rb[15:8], 8'h53);
    check8("R2 enable byte4 quiet", rb[7:0], 8'h00);

    // R6 program writes, low and high byte
    expect_req(3'd1, 10'h234, 1'b0, 8'hA5, "R6 prog write low");
    instr(32'h40_02_34_A5, rb);
    expect_req(3'd1, 10'h1FF, 1'b1, 8'h3C, "R6 prog write high");
    instr(32'h48_01_FF_3C, rb);

    // R5 program reads
    expect_req(3'd0, 10'h310, 1'b0, 8'h00, "R5 prog read low");
    instr(32'h20_03_10_00, rb);
    check8("R5 prog read low data", rb[7:0], model(3'd0, 10'h310, 1'b0));
    expect_req(3'd0, 10'h180, 1'b1, 8'h00, "R5 prog read high");
    instr(32'h28_01_80_00, rb);
    check8("R5 prog read high data", rb[7:0], model(3'd0, 10'h180, 1'b1));

    // R7 data memory, address bit 7 ignored
    expect_req(3'd2, 10'h005, 1'b0, 8'h00, "R7 data read");
    instr(32'hA0_FF_85_00, rb);
    check8("R7 data read data", rb[7:0], model(3'd2, 10'h005, 1'b0));
    expect_req(3'd3, 10'h07F, 1'b0, 8'h11, "R7 data write");
    instr(32'hC0_FF_7F_11, rb);

    // R9 lock/fuse read
    lock_state_n = 2'b10; serial_en_fuse_n = 1'b0;
    instr(32'h58_00_00_00, rb);
    check8("R9 lock read 10/0", rb[7:0], 8'h40);
    lock_state_n = 2'b01; serial_en_fuse_n = 1'b1;
    instr(32'h58_00_00_00, rb);
    check8("R9 lock read 01/1", rb[7:0], 8'hA0);

    // R10 lock write
    expect_req(3'd5, 10'h000, 1'b0, 8'hF9, "R10 lock write");
    instr(32'hAC_F9_00_00, rb);

    // R11 signature read, unlocked and locked
    lock_state_n = 2'b11;
    expect_req(3'd6, 10'h002, 1'b0, 8'h00, "R11 sig read");
    instr(32'h30_00_FE_00, rb);
    check8("R11 sig read data", rb[7:0], model(3'd6, 10'h002, 1'b0));
    lock_state_n = 2'b00;
    instr(32'h30_00_01_00, rb);
    check8("R11 sig read locked", rb[7:0], 8'h00);
    lock_state_n = 2'b11;

    // R8 chip erase
    expect_req(3'd4, 10'h000, 1'b0, 8'h00, "R8 chip erase");
    instr(32'hAC_9F_00_00, rb);

    // R12 unrecognized opcode
    instr(32'h12_34_56_78, rb);
    check8("R12 unknown byte3", rb[15:8], 8'h00);
    check8("R12 unknown byte4", rb[7:0], 8'h00);

    // R13 held request under back-pressure
    req_ready = 1'b0;
    expect_req(3'd3, 10'h009, 1'b0, 8'h5A, "R13 held data write");
    instr(32'hC0_00_09_5A, rb);
    pause(20);
    check8("R13 held valid", {7'b0, req_valid}, 8'h01);
    check8("R13 held op", {5'b0, req_op}, 8'h03);
    check8("R13 held wdata", req_wdata, 8'h5A);
    req_ready = 1'b1;
    pause(5);

    // R4 deselect mid-instruction, framing restarts, enable lost
    begin
      logic [7:0] tmp;
      xfer(8'h12, tmp);
      xfer(8'h34, tmp);
    end
    prog_sel_n = 1'b1;
    pause(10);
    check8("R4 deselected miso", {7'b0, miso}, 8'h00);
    prog_sel_n = 1'b0;
    pause(10);
    instr(32'hC0_00_01_22, rb);
    instr(32'hAC_53_00_00, rb);
    check8("R4 reselect enable echo", rb[15:8], 8'h53);
    expect_req(3'd3, 10'h001, 1'b0, 8'h22, "R4 write after re-enable");
    instr(32'hC0_00_01_22, rb);

    pause(20);
    check8("R13 all expected requests seen", exp_q.size()[7:0], 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule